// File: doc/BRIEF.md
# Status-Coded I2C Master Byte Engine

This block is an I2C bus master that a processor steps through a transfer one bus event at a time. Software writes a control register and a data register. The engine then makes a single bus event: a START, a repeated START, a STOP, or one byte with its acknowledge bit. When the event completes, the engine raises a flag, publishes an 8-bit status code that names the outcome, and holds SCL low until software acts again. Software never tracks bus timing itself. It reads the status code and writes the next action.

Bit timing comes from a phase strobe supplied from outside. Every bit takes four strobes:
- set SDA while SCL is low;
- release SCL;
- sample SDA while SCL is high;
- pull SCL low again.

A 10-bit address is sent as two address phases. Each phase has its own status codes. If another master wins the bus while this one is sending a released bit, the engine lets go of both lines and reports the loss.

Top module: `i2c_stat_master`

## Requirements
- R1: After reset, status is 0xF8, the flag and the interrupt are low, and neither SCL nor SDA is driven.
- R2: Control bit 0x40 enables the engine. With it set, control bit 0x20 starts a transfer once the bus is free. The START gives status 0x08 with the flag set. With 0x40 clear, a START request makes no bus activity. A STOP request while idle changes nothing.
- R3: The data register (select 0) is shifted out MSB first as the first address byte, with bit 0 as the direction bit. The status is 0x18 (acknowledged) or 0x20 (not acknowledged) for a write address, and 0x40 or 0x48 for a read address.
- R4: A data byte written to the bus gives status 0x28 when acknowledged and 0x30 when not.
- R5: A received byte is shifted in MSB first and appears on the data output. The master answers with ACK when control bit 0x04 is set, giving status 0x50. When 0x04 is clear it answers with NACK, giving status 0x58.
- R6: Control bit 0x20 written while stalled inside a transfer makes a repeated START with status 0x10.
- R7: Control bit 0x10 with enable makes a STOP condition. The engine then goes idle with status 0xF8, the flag clear and both lines released.
- R8: A first address byte of the form 11110xxD selects 10-bit mode, and the next byte is a second address phase. That phase gives 0xD0 or 0xD8 for a write, and 0xE0 or 0xE8 for a read (acknowledged or not).
- R9: If SDA is read low while the engine is sending a released bit, arbitration is lost. Both lines are released, and status 0x38 is set with the flag.
- R10: While the flag is set, SCL is held low and the status holds. Writing control with bit 0x08 set leaves the engine stalled. Writing control with bit 0x08 clear resumes it.
- R11: The interrupt output is high exactly when the flag is set and control bit 0x80 is set.
- R12: A write to select 2 (soft reset) returns the engine to idle with status 0xF8. It clears the flag and the control bits and releases both lines.
- R13: STOP and START requested in one write make a STOP condition, then a fresh START with status 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_tick | input | 1 | Quarter-bit strobe from the bus divider |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 data, 1 control, 2 soft reset |
| reg_wdata | input | 8 | Write data |
| data_out | output | 8 | Data register (last received byte) |
| status_out | output | 8 | Status code |
| flag_out | output | 1 | Event-complete flag |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
A wrong phase or direction register does not stay hidden. It surfaces at the next completed event, one byte later at most, as a status code from the wrong family: a write code during a read, or a 10-bit code without a 10-bit first byte. A wrong stall state shows within a few strobes. Either SCL is released while the flag is still set, or the bus model sees extra clock edges without a control write. A lost or extra STOP shows up in the bench's count of STOP conditions on the bus model.

// File: rtl/i2c_stat_master.sv
module i2c_stat_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_tick,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] data_out,
  output logic [7:0] status_out,
  output logic       flag_out,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int B_ACK = 2;
  localparam int B_FLG = 3;
  localparam int B_STO = 4;
  localparam int B_STA = 5;
  localparam int B_EN  = 6;
  localparam int B_IEN = 7;
  localparam logic [7:0] S_IDLE = 8'hF8;
  localparam logic [7:0] S_LOST = 8'h38;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_STALL, ST_STOP} st_t;
  typedef enum logic [1:0] {PH_ADDR1, PH_ADDR2, PH_WDATA, PH_RDATA} ph_t;

  st_t        st;
  ph_t        ph;
  logic [1:0] q;
  logic [3:0] bc;
  logic [7:0] sh, dat, stat;
  logic       flg, en, ien, ackc, sta, sto;
  logic       dir, ten, rep, ack_smp;
  logic       scl_d, sda_d;
  logic [7:0] done_code;

  wire go       = en && !flg;
  wire tx_phase = (ph != PH_RDATA);
  wire ack_slot = (bc == 4'd8);

  always_comb begin
    case (ph)
      PH_ADDR1: done_code = dir ? (ack_smp ? 8'h40 : 8'h48) : (ack_smp ? 8'h18 : 8'h20);
      PH_ADDR2: done_code = dir ? (ack_smp ? 8'hE0 : 8'hE8) : (ack_smp ? 8'hD0 : 8'hD8);
      PH_WDATA: done_code = ack_smp ? 8'h28 : 8'h30;
      default:  done_code = ackc ? 8'h50 : 8'h58;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR1; q <= 2'd0; bc <= 4'd0;
      sh <= 8'h00; dat <= 8'h00; stat <= S_IDLE;
      flg <= 1'b0; en <= 1'b0; ien <= 1'b0; ackc <= 1'b0; sta <= 1'b0; sto <= 1'b0;
      dir <= 1'b0; ten <= 1'b0; rep <= 1'b0; ack_smp <= 1'b0;
      scl_d <= 1'b0; sda_d <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go && sta && scl_in && sda_in) begin
            st <= ST_START; q <= 2'd0; rep <= 1'b0; sta <= 1'b0;
          end else if (go && sto) begin
            sto <= 1'b0;
          end
        end
        ST_STALL: begin
          if (go) begin
            if (sto) begin
              st <= ST_STOP; q <= 2'd0; sto <= 1'b0;
            end else if (sta) begin
              st <= ST_START; q <= 2'd0; rep <= 1'b1; sta <= 1'b0;
            end else begin
              st <= ST_BIT; q <= 2'd0; bc <= 4'd0;
              sh <= tx_phase ? dat : 8'h00;
              if (ph == PH_ADDR1) begin
                dir <= dat[0];
                ten <= (dat[7:3] == 5'b11110);
              end
            end
          end
        end
        ST_START: begin
          if (phase_tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_d <= 1'b0;
              2'd1: scl_d <= 1'b0;
              2'd2: sda_d <= 1'b1;
              default: begin
                scl_d <= 1'b1; st <= ST_STALL; flg <= 1'b1;
                stat <= rep ? 8'h10 : 8'h08; ph <= PH_ADDR1;
              end
            endcase
          end
        end
        ST_STOP: begin
          if (phase_tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_d <= 1'b1;
              2'd1: scl_d <= 1'b0;
              2'd2: sda_d <= 1'b0;
              default: begin
                st <= ST_IDLE; stat <= S_IDLE;
              end
            endcase
          end
        end
        ST_BIT: begin
          if (phase_tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_d <= ack_slot ? (!tx_phase && ackc) : (tx_phase && !sh[7]);
              2'd1: scl_d <= 1'b0;
              2'd2: begin
                if (ack_slot) begin
                  ack_smp <= !sda_in;
                end else if (tx_phase && sh[7] && !sda_in) begin
                  st <= ST_IDLE; scl_d <= 1'b0; sda_d <= 1'b0;
                  flg <= 1'b1; stat <= S_LOST;
                end else begin
                  sh <= {sh[6:0], sda_in};
                end
              end
              default: begin
                scl_d <= 1'b1;
                if (ack_slot) begin
                  st <= ST_STALL; flg <= 1'b1; stat <= done_code;
                  if (!tx_phase) dat <= sh;
                  if (ph == PH_ADDR1 && ack_smp)
                    ph <= ten ? PH_ADDR2 : (dir ? PH_RDATA : PH_WDATA);
                  else if (ph == PH_ADDR2 && ack_smp)
                    ph <= dir ? PH_RDATA : PH_WDATA;
                end else begin
                  bc <= bc + 4'd1;
                end
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (reg_we) begin
        case (reg_sel)
          2'd0: if (st != ST_BIT) dat <= reg_wdata;
          2'd1: begin
            en   <= reg_wdata[B_EN];
            ien  <= reg_wdata[B_IEN];
            ackc <= reg_wdata[B_ACK];
            sta  <= reg_wdata[B_STA];
            sto  <= reg_wdata[B_STO];
            if (!reg_wdata[B_FLG]) flg <= 1'b0;
          end
          2'd2: begin
            st <= ST_IDLE; stat <= S_IDLE; flg <= 1'b0;
            scl_d <= 1'b0; sda_d <= 1'b0;
            en <= 1'b0; ien <= 1'b0; ackc <= 1'b0; sta <= 1'b0; sto <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign data_out   = dat;
  assign status_out = stat;
  assign flag_out   = flg;
  assign irq        = flg && ien;
  assign scl_oe     = scl_d;
  assign sda_oe     = sda_d;
endmodule

module i2c_stat_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_tick,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [7:0] status_out,
  input logic       flag_out,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R10
  stall_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_out && status_out != 8'h38) |-> scl_oe);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_out && !reg_we) |=> ($stable(status_out) && flag_out));
  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2) |=> (status_out == 8'hF8 && !flag_out && !scl_oe && !sda_oe));
  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_out);
  // R2
  flag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_out) |-> $past(phase_tick));
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_out && status_out == 8'hF8) |-> !scl_oe);
endmodule

bind i2c_stat_master i2c_stat_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .reg_we(reg_we),
  .reg_sel(reg_sel), .status_out(status_out), .flag_out(flag_out),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_i2c_stat_master.sv
`timescale 1ns/1ps
module sim_i2c_stat_master;
  localparam logic [7:0] EN = 8'h40, IEN = 8'h80, ACK = 8'h04, FLG = 8'h08, STO = 8'h10, STA = 8'h20;

  logic clk = 0, rst_n = 0, phase_tick = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] data_out, status_out;
  logic flag_out, irq, scl_oe, sda_oe;
  logic pull = 0, arb_pull = 0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || pull || arb_pull);

  int errors = 0, checks = 0;
  bit done = 0;

  i2c_stat_master u0 (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .data_out(data_out),
    .status_out(status_out), .flag_out(flag_out), .irq(irq),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #2 clk = !clk;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      phase_tick = (cnt % 4 == 0);
    end
  end

  // bus partner model
  int bitc = -1, bytenum = 0, stops = 0;
  bit rd_mode = 0, ten_m = 0, lis_ok = 0, mnack = 0, ackv = 0, ack_en = 1;
  logic [7:0] rx_sh = 0, last_byte = 0, rd_b0 = 0, rd_b1 = 0;

  function automatic bit talking(int k);
    return rd_mode && lis_ok && !mnack && (k >= (ten_m ? 2 : 1));
  endfunction

  always @(negedge sda) if (scl === 1'b1) begin
    bitc = -1; bytenum = 0; rd_mode = 0; ten_m = 0; lis_ok = 0; mnack = 0; pull = 0;
  end
  always @(posedge sda) if (scl === 1'b1) stops++;

  always @(posedge scl) begin
    if (bitc >= 0 && bitc < 8) rx_sh = {rx_sh[6:0], sda};
    else if (bitc == 8) begin
      ackv = !sda;
      if (talking(bytenum)) begin
        if (sda) mnack = 1;
      end else begin
        lis_ok = !sda;
        if (bytenum == 0) begin
          rd_mode = rx_sh[0];
          ten_m = (rx_sh[7:3] == 5'b11110);
        end
      end
      last_byte = rx_sh;
      bytenum++;
    end
  end

  always @(negedge scl) begin
    logic [7:0] tb;
    bitc++;
    if (bitc == 9) bitc = 0;
    tb = (bytenum == (ten_m ? 2 : 1)) ? rd_b0 : rd_b1;
    if (bitc == 8) pull = !talking(bytenum) && ack_en;
    else if (bitc >= 0 && bitc < 8 && talking(bytenum)) pull = !tb[7-bitc];
    else pull = 0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_flag(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (flag_out) return;
    end
    chk(0, req, "flag timeout", 0, 1);
  endtask

  task automatic do_start(input logic [7:0] ctl, input logic [7:0] exp, input string req);
    wr(1, ctl);
    wait_flag(req);
    chk(status_out == exp, req, "start status", status_out, exp);
  endtask

  task automatic byte_op(input logic [7:0] d, input logic [7:0] ctl, input logic [7:0] exp, input string req);
    wr(0, d);
    wr(1, ctl);
    wait_flag(req);
    chk(status_out == exp, req, "byte status", status_out, exp);
  endtask

  task automatic do_stop(input string req);
    wr(1, EN | STO);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status_out == 8'hF8) break;
    end
    repeat (8) @(negedge clk);
    chk(status_out == 8'hF8 && !flag_out, req, "stop idle", status_out, 8'hF8);
  endtask

  task automatic t_reset;
    chk(status_out == 8'hF8, "R1", "status", status_out, 8'hF8);
    chk(!flag_out && !irq, "R1", "flag/irq", {flag_out, irq}, 0);
    chk(!scl_oe && !sda_oe, "R1", "lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_enable;
    wr(1, STA);
    repeat (100) @(negedge clk);
    chk(status_out == 8'hF8 && !flag_out && !scl_oe, "R2", "start without enable", status_out, 8'hF8);
    wr(1, 8'h00);
    wr(1, EN | STO);
    repeat (60) @(negedge clk);
    chk(status_out == 8'hF8 && !flag_out && !scl_oe && !sda_oe, "R2", "stop while idle", status_out, 8'hF8);
  endtask

  task automatic t_write;
    int s0;
    ack_en = 1;
    do_start(EN | IEN | STA, 8'h08, "R2");
    chk(irq == 1, "R11", "irq with enable", irq, 1);
    chk(scl_oe == 1, "R10", "scl held", scl_oe, 1);
    repeat (60) @(negedge clk);
    chk(flag_out && status_out == 8'h08, "R10", "stall holds", status_out, 8'h08);
    wr(0, 8'hA4);
    wr(1, EN | IEN | FLG);
    repeat (80) @(negedge clk);
    chk(flag_out && status_out == 8'h08, "R10", "flag-set write keeps stall", status_out, 8'h08);
    wr(1, EN | IEN);
    wait_flag("R3");
    chk(status_out == 8'h18, "R3", "write addr ack", status_out, 8'h18);
    chk(last_byte == 8'hA4, "R3", "addr on bus", last_byte, 8'hA4);
    byte_op(8'h3C, EN | IEN, 8'h28, "R4");
    chk(last_byte == 8'h3C, "R4", "data on bus", last_byte, 8'h3C);
    ack_en = 0;
    byte_op(8'hC5, EN | IEN, 8'h30, "R4");
    ack_en = 1;
    s0 = stops;
    do_stop("R7");
    chk(stops == s0 + 1, "R7", "stop condition seen", stops, s0 + 1);
    chk(!scl_oe && !sda_oe && !irq, "R7", "lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_irq_off;
    do_start(EN | STA, 8'h08, "R11");
    chk(flag_out && !irq, "R11", "irq masked", irq, 0);
    do_stop("R7");
  endtask

  task automatic t_addr_nack;
    ack_en = 0;
    do_start(EN | STA, 8'h08, "R2");
    byte_op(8'hA4, EN, 8'h20, "R3");
    do_stop("R7");
    do_start(EN | STA, 8'h08, "R2");
    byte_op(8'h91, EN, 8'h48, "R3");
    do_stop("R7");
    ack_en = 1;
  endtask

  task automatic t_read;
    rd_b0 = 8'h9A; rd_b1 = 8'h65;
    do_start(EN | STA, 8'h08, "R2");
    byte_op(8'h91, EN, 8'h40, "R3");
    wr(1, EN | ACK);
    wait_flag("R5");
    chk(status_out == 8'h50, "R5", "read ack status", status_out, 8'h50);
    chk(data_out == 8'h9A, "R5", "first byte", data_out, 8'h9A);
    chk(ackv == 1, "R5", "ack on bus", ackv, 1);
    wr(1, EN);
    wait_flag("R5");
    chk(status_out == 8'h58, "R5", "read nack status", status_out, 8'h58);
    chk(data_out == 8'h65, "R5", "second byte", data_out, 8'h65);
    chk(ackv == 0, "R5", "nack on bus", ackv, 0);
    do_stop("R7");
  endtask

  task automatic t_rstart;
    do_start(EN | STA, 8'h08, "R2");
    byte_op(8'hA4, EN, 8'h18, "R3");
    do_start(EN | STA, 8'h10, "R6");
    byte_op(8'hA4, EN, 8'h18, "R6");
    do_stop("R7");
  endtask

  task automatic t_ten;
    do_start(EN | STA, 8'h08, "R8");
    byte_op(8'hF2, EN, 8'h18, "R8");
    chk(last_byte == 8'hF2, "R8", "first addr byte", last_byte, 8'hF2);
    byte_op(8'h34, EN, 8'hD0, "R8");
    chk(last_byte == 8'h34, "R8", "second addr byte", last_byte, 8'h34);
    byte_op(8'h5A, EN, 8'h28, "R8");
    do_stop("R7");
    do_start(EN | STA, 8'h08, "R8");
    byte_op(8'hF2, EN, 8'h18, "R8");
    ack_en = 0;
    byte_op(8'h35, EN, 8'hD8, "R8");
    ack_en = 1;
    do_stop("R7");
    rd_b0 = 8'hC3;
    do_start(EN | STA, 8'h08, "R8");
    byte_op(8'hF3, EN, 8'h40, "R8");
    byte_op(8'h34, EN, 8'hE0, "R8");
    wr(1, EN);
    wait_flag("R8");
    chk(status_out == 8'h58 && data_out == 8'hC3, "R8", "10-bit read byte", data_out, 8'hC3);
    do_stop("R7");
  endtask

  task automatic t_stopstart;
    int s0;
    do_start(EN | STA, 8'h08, "R13");
    byte_op(8'hA4, EN, 8'h18, "R13");
    s0 = stops;
    wr(1, EN | STO | STA);
    wait_flag("R13");
    chk(status_out == 8'h08, "R13", "fresh start status", status_out, 8'h08);
    chk(stops == s0 + 1, "R13", "stop before start", stops, s0 + 1);
    do_stop("R7");
  endtask

  task automatic t_arb;
    do_start(EN | STA, 8'h08, "R9");
    arb_pull = 1;
    byte_op(8'h80, EN, 8'h38, "R9");
    chk(!scl_oe && !sda_oe, "R9", "lines released", {scl_oe, sda_oe}, 0);
    arb_pull = 0;
    wr(2, 8'h00);
    chk(status_out == 8'hF8 && !flag_out, "R12", "reset after loss", status_out, 8'hF8);
  endtask

  task automatic t_sreset;
    do_start(EN | IEN | STA, 8'h08, "R12");
    chk(sda_oe && scl_oe, "R12", "lines held before reset", {scl_oe, sda_oe}, 3);
    wr(2, 8'h00);
    chk(status_out == 8'hF8 && !flag_out && !irq, "R12", "soft reset state", status_out, 8'hF8);
    chk(!scl_oe && !sda_oe, "R12", "soft reset lines", {scl_oe, sda_oe}, 0);
    repeat (60) @(negedge clk);
    chk(status_out == 8'hF8 && !flag_out, "R12", "control cleared", status_out, 8'hF8);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_write();
    t_irq_off();
    t_addr_nack();
    t_read();
    t_rstart();
    t_ten();
    t_stopstart();
    t_arb();
    t_sreset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule